// File: doc/BRIEF.md
# Transition Count Response Compactor

This block reduces the responses that a multi-output circuit under test produces during a self-test run to one number. On each valid cycle it compares every response bit with the same bit from the previous valid sample and adds the number of bits that changed to a running total. A change counts whether the bit went up or down. The changes on all outputs are added into one shared counter.

At the end of a run the test controller applies the count expected from a fault-free circuit on `golden` and pulses `done`. The block then reports through `pass` whether the accumulated signature matches that value. A synchronous clear starts a new run without a full reset. The counter saturates rather than wraps, so a very noisy faulty response cannot wrap around and land on the good value.

Top module: `trans_count_compactor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count` becomes 0 and `pass` becomes 0.
- R2: A cycle with `clr` high sets `count` to 0 and forgets the stored previous sample. A `valid` sample in that same cycle is discarded.
- R3: The first `valid` sample after reset or clear only stores the response as the previous sample. `count` does not change.
- R4: Each later `valid` sample adds the number of 1 bits in (`resp` XOR previous valid sample) to `count` at the next edge. Rising and falling bits both count, and the sample then becomes the new previous sample.
- R5: In cycles with `valid` low, neither `count` nor the stored previous sample changes, whatever `resp` carries.
- R6: Changes on all WIDTH response bits in one sample are summed into the single counter. A long sequence yields the sum over its consecutive sample pairs.
- R7: `count` saturates at 2^CNT_W-1. An addition that would exceed it leaves `count` at that maximum.
- R8: `pass` is 1 in the cycle after a `done` cycle exactly when `count` equalled `golden` at that edge. In every other cycle `pass` is 0.
- R9: On a single toggling output, the serial responses 01000111, 01110111, 11111111 and 00001111 give counts of 3, 3, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous start-of-run clear |
| valid | input | 1 | Response word is a sample |
| resp | input | WIDTH | Response word from the circuit under test |
| golden | input | CNT_W | Expected fault-free count |
| done | input | 1 | End-of-run strobe, requests a verdict |
| count | output | CNT_W | Accumulated transition count |
| pass | output | 1 | Verdict, high the cycle after done when count matched golden |

## Verification
The hardest case to reach is a saturated counter that is then offered further transitions. It only arises after enough toggling samples to fill the counter. The bench therefore builds the block with a 3-bit response and a 4-bit counter, so six alternating all-zero and all-one samples push it over the limit, and each step is compared with the clipped arithmetic total. The pairwise sweep primes every one of the 64 ordered word pairs after a clear. Idle cycles carry decoy words that would change the result if the stored sample were overwritten.

// File: rtl/tcc_pkg.sv
// Package: shared helpers for the transition count compactor.
// Assumes widths are small positive integers chosen at elaboration.
package tcc_pkg;

    // Width needed to hold a population count of n bits.
    function automatic int unsigned pop_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Larger of two widths.
    function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tcc_edge_detect.sv
// Module: tcc_edge_detect
// Holds the previous valid response word and flags the bits that changed.
// Assumes clr has priority over valid. The first valid sample after reset or
// clear only primes the store and does not enable accumulation.
module tcc_edge_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic [WIDTH-1:0] resp,
    output logic [WIDTH-1:0] diff,
    output logic             add_en,
    output logic             primed
);
    logic [WIDTH-1:0] prev_q;
    logic             primed_q;

    // Store the last valid sample and remember whether one exists.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (valid) begin
            prev_q   <= resp;
            primed_q <= 1'b1;
        end
    end

    // Bits that moved against the stored sample, in either direction.
    always_comb begin
        diff   = resp ^ prev_q;
        add_en = valid && primed_q && !clr;
    end

    assign primed = primed_q;

    // R2
    clear_unprimes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !primed_q);

    // R5
    idle_holds_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr) |=> $stable(prev_q));

endmodule

// File: rtl/tcc_popcount.sv
// Module: tcc_popcount
// Counts the set bits of a word with a generated ripple of partial sums.
// Assumes the output width is wide enough for WIDTH ones.
module tcc_popcount #(
    parameter int WIDTH = 8,
    parameter int PW    = tcc_pkg::pop_width(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [PW-1:0]    ones
);
    logic [PW-1:0] partial [WIDTH+1];

    assign partial[0] = '0;

    // One adder stage for each response bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign partial[i+1] = partial[i] + PW'(bits[i]);
    end

    assign ones = partial[WIDTH];

    // R6
    ones_bound_chk: assert final (ones <= PW'(WIDTH));

endmodule

// File: rtl/tcc_sat_acc.sv
// Module: tcc_sat_acc
// Saturating accumulator for the transition signature.
// Assumes clr has priority over add_en, and that inc fits into the sum width.
module tcc_sat_acc #(
    parameter int CNT_W = 12,
    parameter int PW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [PW-1:0]    inc,
    output logic [CNT_W-1:0] count
);
    localparam int SW = tcc_pkg::max_w(CNT_W, PW) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [SW-1:0]    sum;
    logic [CNT_W-1:0] next_sat;

    // Widened sum, clipped to the counter ceiling.
    always_comb begin
        sum      = SW'(count_q) + SW'(inc);
        next_sat = (sum > SW'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
    end

    // Counter register with clear and enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (add_en) begin
            count_q <= next_sat;
        end
    end

    assign count = count_q;

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> (count_q >= $past(count_q)));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == CNT_MAX) && !clr) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/tcc_verdict.sv
// Module: tcc_verdict
// Registers the end-of-run comparison against the expected signature.
// Assumes done is a single-cycle strobe. The verdict is shown for one cycle.
module tcc_verdict #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] golden,
    output logic             pass
);
    logic pass_q;

    // Sample the match only when done requests it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= done && (count == golden);
        end
    end

    assign pass = pass_q;

    // R8
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> !pass_q);

endmodule

// File: rtl/trans_count_compactor.sv
// Module: trans_count_compactor (top)
// Compacts a WIDTH-bit response stream into a saturating count of bit
// transitions and checks it against an expected value at the end of a run.
// Assumes the synchronous reset is active low and clr starts a new run.
module trans_count_compactor #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic [WIDTH-1:0] resp,
    input  logic [CNT_W-1:0] golden,
    input  logic             done,
    output logic [CNT_W-1:0] count,
    output logic             pass
);
    localparam int PW = tcc_pkg::pop_width(WIDTH);

    logic [WIDTH-1:0] diff;
    logic             add_en;
    logic             primed;
    logic [PW-1:0]    ones;

    tcc_edge_detect #(.WIDTH(WIDTH)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .valid  (valid),
        .resp   (resp),
        .diff   (diff),
        .add_en (add_en),
        .primed (primed)
    );

    tcc_popcount #(.WIDTH(WIDTH), .PW(PW)) pop_i (
        .bits (diff),
        .ones (ones)
    );

    tcc_sat_acc #(.CNT_W(CNT_W), .PW(PW)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .add_en (add_en),
        .inc    (ones),
        .count  (count)
    );

    tcc_verdict #(.CNT_W(CNT_W)) verdict_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (done),
        .count  (count),
        .golden (golden),
        .pass   (pass)
    );

    // R3
    prime_adds_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !primed && !clr) |=> $stable(count));

    // R5
    idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr) |=> $stable(count));

endmodule

// File: tb/trans_count_compactor_tb_top.sv
`timescale 1ns/1ps
module trans_count_compactor_tb_top;
    localparam int W  = 3;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clr;
    logic          valid;
    logic [W-1:0]  resp;
    logic [CW-1:0] golden;
    logic          done;
    logic [CW-1:0] count;
    logic          pass;

    int checks = 0;
    int fails  = 0;

    trans_count_compactor #(.WIDTH(W), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .resp(resp),
        .golden(golden), .done(done), .count(count), .pass(pass)
    );

    always #2 clk = ~clk;

    function automatic int ones(input int v);
        int n = 0;
        for (int b = 0; b < W; b++) n += (v >> b) & 1;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply inputs for one cycle, then sample just after the edge.
    task automatic drive(input logic v, input int r, input logic c, input logic d);
        valid = v; resp = W'(r); clr = c; done = d;
        @(posedge clk);
        #1;
        valid = 1'b0; clr = 1'b0; done = 1'b0;
    endtask

    task automatic serial(input logic [7:0] bits, input int exp);
        drive(1'b0, 0, 1'b1, 1'b0);
        for (int i = 7; i >= 0; i--) drive(1'b1, {2'b00, bits[i]}, 1'b0, 1'b0);
        check("R9 serial", count, exp);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int exp;
        int prev;
        rst_n = 1'b0; clr = 1'b0; valid = 1'b0; resp = '0; golden = '0; done = 1'b0;
        drive(1'b1, 7, 1'b0, 1'b1);
        drive(1'b1, 0, 1'b0, 1'b1);
        check("R1 count", count, 0);
        check("R1 pass", pass, 0);
        rst_n = 1'b1;

        // R3 R4 R6: every ordered pair of words after a clear
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                drive(1'b0, 0, 1'b1, 1'b0);
                drive(1'b1, a, 1'b0, 1'b0);
                if (b == 0) check("R3 prime", count, 0);
                drive(1'b1, b, 1'b0, 1'b0);
                check("R4 pair", count, ones(a ^ b));
            end
        end

        // R6: binary sequence 0..7 summed over consecutive pairs
        drive(1'b0, 0, 1'b1, 1'b0);
        exp = 0; prev = 0;
        for (int k = 0; k < (1 << W); k++) begin
            drive(1'b1, k, 1'b0, 1'b0);
            if (k > 0) exp += ones(k ^ prev);
            prev = k;
        end
        check("R6 sequence", count, exp);

        // R5: idle cycles with decoy words leave count and stored sample alone
        drive(1'b0, 0, 1'b1, 1'b0);
        drive(1'b1, 5, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 2, 1'b0, 1'b0);
            check("R5 idle count", count, 0);
        end
        drive(1'b1, 4, 1'b0, 1'b0);
        check("R5 prev kept", count, 1);

        // R2: clear beats a same-cycle sample
        drive(1'b1, 0, 1'b0, 1'b0);
        check("R2 before clear", count, 2);
        drive(1'b1, 7, 1'b1, 1'b0);
        check("R2 cleared", count, 0);
        drive(1'b1, 0, 1'b0, 1'b0);
        check("R2 sample discarded", count, 0);
        drive(1'b1, 7, 1'b0, 1'b0);
        check("R2 restart", count, 3);

        // R7: saturation with alternating all-zero and all-one words
        drive(1'b0, 0, 1'b1, 1'b0);
        drive(1'b1, 0, 1'b0, 1'b0);
        for (int k = 1; k <= 7; k++) begin
            drive(1'b1, (k % 2) ? 7 : 0, 1'b0, 1'b0);
            check("R7 saturate", count, (3 * k > CMAX) ? CMAX : 3 * k);
        end

        // R9: serial responses on one output
        serial(8'b01000111, 3);
        serial(8'b01110111, 3);
        serial(8'b11111111, 0);
        serial(8'b00001111, 1);

        // R8: verdict against golden (count is 1 here)
        golden = CW'(1);
        drive(1'b0, 0, 1'b0, 1'b0);
        check("R8 no done", pass, 0);
        drive(1'b0, 0, 1'b0, 1'b1);
        check("R8 match", pass, 1);
        drive(1'b0, 0, 1'b0, 1'b0);
        check("R8 one cycle", pass, 0);
        golden = CW'(2);
        drive(1'b0, 0, 1'b0, 1'b1);
        check("R8 mismatch", pass, 0);
        golden = CW'(1);
        drive(1'b1, 0, 1'b0, 1'b1);
        check("R8 compare before sample", pass, 1);
        check("R8 sample counted", count, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule